// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block decides how much of a serial interface device is powered. It has three states. In the awake state everything runs. In the light sleep state the oscillator is stopped but the charge pump stays on. In the deep sleep state both the oscillator and the charge pump are off. The block drives one enable for each of these, plus an enable for the receive-line monitor, which it holds on in every state. That way, activity on the serial input can always bring the device back.

A sleep request can come from a software control bit or from a hardware request line. The block goes to light sleep only when several conditions hold at once:
- a request is present;
- both serial paths are idle;
- no interrupt is pending;
- no wake event is present.

An external autosleep pin moves the block from light sleep to deep sleep. This pin only takes effect in light sleep. Activity on the receive line, or a host bus access, wakes the block from either sleep state. Each wake sets a sticky wake-up interrupt flag, which a read of the interrupt status clears.

After a wake from deep sleep, the charge pump needs time to settle. The block holds its ready output low while it counts a set number of pulses from a free-running low-rate timer.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the block is awake: `pm_state` = 0, `osc_en` = 1, `pump_en` = 1, `wake_irq` = 0 and `ready` = 1.
- R2: The state is reported on `pm_state` as 0 = awake, 1 = light sleep and 2 = deep sleep. `osc_en` is 1 only in state 0, and `pump_en` is 0 only in state 2.
- R3: From awake, the block enters light sleep at the next clock edge when all of the following hold:
  - `sw_sleep` or `hw_sleep` is 1;
  - `tx_idle` and `rx_idle` are both 1;
  - `irq_pending` is 0 and `wake_irq` is 0;
  - `rx_activity` and `bus_access` are both 0;
  - `ready` is 1.
- R4: If any one of the R3 conditions fails, the block stays awake even while a sleep request is present.
- R5: `autosleep` high in light sleep, with no wake event, moves the block to deep sleep at the next edge. In the awake state, `autosleep` has no effect.
- R6: `rx_activity` or `bus_access` in either sleep state returns the block to awake at the next edge. In light sleep, a wake event takes priority over `autosleep`.
- R7: `wake_irq` is set at the edge that leaves a sleep state. It then stays set until an `isr_read` pulse clears it. If a set and a clear fall on the same edge, the set wins.
- R8: After a wake from deep sleep, `ready` is 0 until WAKE_TICKS `tick` pulses have been counted. After a wake from light sleep, `ready` is 1 at once.
- R9: `rx_mon_en` is 1 in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pulse from the low-rate timer |
| sw_sleep | input | 1 | Software sleep request bit |
| hw_sleep | input | 1 | Hardware sleep request |
| autosleep | input | 1 | Deep-sleep request pin, active high |
| tx_idle | input | 1 | Transmit path is empty and idle |
| rx_idle | input | 1 | Receive path is empty and idle |
| irq_pending | input | 1 | Another interrupt source is active |
| rx_activity | input | 1 | Edge seen on the receive line |
| bus_access | input | 1 | Host bus cycle addressed to the device |
| isr_read | input | 1 | Read of the interrupt status; clears the wake flag |
| osc_en | output | 1 | Oscillator enable |
| pump_en | output | 1 | Charge pump enable |
| rx_mon_en | output | 1 | Receive-line monitor enable |
| wake_irq | output | 1 | Sticky wake-up interrupt flag |
| ready | output | 1 | Awake and charge pump settled |
| pm_state | output | 2 | Current power state |

## Verification
The sleep-entry gate is driven with each blocking condition raised alone while a request is held:
- a busy transmit path;
- a busy receive path;
- a pending interrupt;
- an uncleared wake flag.

This shows that each condition vetoes entry on its own. The two request sources are each used alone, and they are shown to enter the same state. Wake-ups are made from both sleep depths, by line activity and by bus access. This separates the immediate-ready case from the timed-settle case. A wake event is also made to coincide with `autosleep`, and a status read is made to coincide with a wake. These two cases expose the priority rules. A behavioural model computed in the bench is compared with every output on every cycle.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_AWAKE = 2'd0,
        PM_LIGHT = 2'd1,
        PM_DEEP  = 2'd2
    } pm_state_t;

    typedef struct packed {
        logic osc;
        logic pump;
        logic rxmon;
    } pm_rails_t;

    function automatic pm_rails_t pm_rails(input pm_state_t s);
        pm_rails_t r;
        r.osc   = (s == PM_AWAKE);
        r.pump  = (s != PM_DEEP);
        r.rxmon = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pm_sequencer.sv
module pm_sequencer
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_req,
    input  logic      quiet,
    input  logic      settled,
    input  logic      wake_evt,
    input  logic      autosleep,
    output pm_state_t state,
    output logic      leave_any,
    output logic      leave_deep
);
    pm_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PM_AWAKE: if (sleep_req && quiet && settled && !wake_evt) nxt = PM_LIGHT;
            PM_LIGHT: begin
                if (wake_evt)       nxt = PM_AWAKE;
                else if (autosleep) nxt = PM_DEEP;
            end
            PM_DEEP:  if (wake_evt) nxt = PM_AWAKE;
            default:  nxt = PM_AWAKE;
        endcase
    end

    assign leave_any  = (state != PM_AWAKE) && wake_evt;
    assign leave_deep = (state == PM_DEEP) && wake_evt;

    always_ff @(posedge clk) begin
        if (rst) state <= PM_AWAKE;
        else     state <= nxt;
    end
endmodule

// File: rtl/pm_settle_timer.sv
module pm_settle_timer #(
    parameter int unsigned WAKE_TICKS = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic settled
);
    localparam int unsigned CW = $clog2(WAKE_TICKS + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                   cnt <= '0;
        else if (load)             cnt <= LOAD_VAL;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign settled = (cnt == '0);
endmodule

// File: rtl/pm_wake_flag.sv
module pm_wake_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned WAKE_TICKS = 45
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sw_sleep,
    input  logic       hw_sleep,
    input  logic       autosleep,
    input  logic       tx_idle,
    input  logic       rx_idle,
    input  logic       irq_pending,
    input  logic       rx_activity,
    input  logic       bus_access,
    input  logic       isr_read,
    output logic       osc_en,
    output logic       pump_en,
    output logic       rx_mon_en,
    output logic       wake_irq,
    output logic       ready,
    output logic [1:0] pm_state
);
    pm_state_t state;
    pm_rails_t rails;
    logic      leave_any, leave_deep, settled, wake_evt, quiet;

    assign wake_evt = rx_activity | bus_access;
    assign quiet    = tx_idle & rx_idle & ~irq_pending & ~wake_irq;

    pm_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .sleep_req  (sw_sleep | hw_sleep),
        .quiet      (quiet),
        .settled    (settled),
        .wake_evt   (wake_evt),
        .autosleep  (autosleep),
        .state      (state),
        .leave_any  (leave_any),
        .leave_deep (leave_deep)
    );

    pm_settle_timer #(.WAKE_TICKS(WAKE_TICKS)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (leave_deep),
        .tick    (tick),
        .settled (settled)
    );

    pm_wake_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (leave_any),
        .clr  (isr_read),
        .flag (wake_irq)
    );

    assign rails     = pm_rails(state);
    assign osc_en    = rails.osc;
    assign pump_en   = rails.pump;
    assign rx_mon_en = rails.rxmon;
    assign ready     = (state == PM_AWAKE) && settled;
    assign pm_state  = state;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       autosleep,
    input logic       rx_activity,
    input logic       bus_access,
    input logic       isr_read,
    input logic       wake_irq,
    input logic       ready,
    input logic [1:0] pm_state
);
    AST_AUTOSLEEP_DEEPENS: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'd1 && autosleep && !rx_activity && !bus_access) |=> pm_state == 2'd2); // R5
    AST_NO_DEEP_FROM_AWAKE: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'd0) |=> pm_state != 2'd2); // R5
    AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (pm_state != 2'd0 && (rx_activity || bus_access)) |=> pm_state == 2'd0); // R6
    AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (rst)
        (pm_state != 2'd0 && (rx_activity || bus_access)) |=> wake_irq); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wake_irq && !isr_read) |=> wake_irq); // R7
    AST_DEEP_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'd2 && (rx_activity || bus_access)) |=> !ready); // R8
    AST_LIGHT_WAKE_READY: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'd1 && (rx_activity || bus_access)) |=> ready); // R8
    AST_NO_ENTRY_UNSETTLED: assert property (@(posedge clk) disable iff (rst)
        (pm_state == 2'd0 && !ready) |=> pm_state == 2'd0); // R3
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .autosleep   (autosleep),
    .rx_activity (rx_activity),
    .bus_access  (bus_access),
    .isr_read    (isr_read),
    .wake_irq    (wake_irq),
    .ready       (ready),
    .pm_state    (pm_state)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
    localparam int CLK_P = 10;
    localparam int WT    = 45;

    logic clk = 0, rst = 1, tick = 0;
    logic sw_sleep = 0, hw_sleep = 0, autosleep = 0;
    logic tx_idle = 1, rx_idle = 1, irq_pending = 0;
    logic rx_activity = 0, bus_access = 0, isr_read = 0;
    logic osc_en, pump_en, rx_mon_en, wake_irq, ready;
    logic [1:0] pm_state;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    int m_state = 0, m_cnt = 0;
    bit m_flag = 0;

    always #(CLK_P/2) clk = ~clk;

    pwr_mode_ctrl #(.WAKE_TICKS(WT)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .sw_sleep(sw_sleep), .hw_sleep(hw_sleep),
        .autosleep(autosleep), .tx_idle(tx_idle), .rx_idle(rx_idle),
        .irq_pending(irq_pending), .rx_activity(rx_activity), .bus_access(bus_access),
        .isr_read(isr_read), .osc_en(osc_en), .pump_en(pump_en), .rx_mon_en(rx_mon_en),
        .wake_irq(wake_irq), .ready(ready), .pm_state(pm_state));

    // behavioural reference model
    always @(posedge clk) begin
        bit wk;
        int ns;
        wk = rx_activity || bus_access;
        ns = m_state;
        if (rst) begin
            m_state <= 0; m_flag <= 0; m_cnt <= 0;
        end else begin
            if (m_state == 0) begin
                if ((sw_sleep || hw_sleep) && tx_idle && rx_idle && !irq_pending
                    && !m_flag && !wk && m_cnt == 0) ns = 1;
            end else if (m_state == 1) begin
                if (wk) ns = 0; else if (autosleep) ns = 2;
            end else if (wk) ns = 0;
            m_state <= ns;
            if (m_state != 0 && wk) m_flag <= 1;
            else if (isr_read)      m_flag <= 0;
            if (m_state == 2 && wk)     m_cnt <= WT;
            else if (tick && m_cnt > 0) m_cnt <= m_cnt - 1;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // per-cycle compare, away from the active edge
    always @(negedge clk) begin
        cyc++;
        tick <= (cyc % 4 == 0);
        if (!rst && !done) begin
            chk("R2", "pm_state", pm_state, m_state);
            chk("R2", "osc_en", osc_en, m_state == 0);
            chk("R2", "pump_en", pump_en, m_state != 2);
            chk("R9", "rx_mon_en", rx_mon_en, 1);
            chk("R7", "wake_irq", wake_irq, m_flag);
            chk("R8", "ready", ready, (m_state == 0) && (m_cnt == 0));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        chk("R1", "state", pm_state, 0);
        chk("R1", "osc_en", osc_en, 1);
        chk("R1", "pump_en", pump_en, 1);
        chk("R1", "wake_irq", wake_irq, 0);
        chk("R1", "ready", ready, 1);

        // R4: each blocking condition alone keeps the block awake
        sw_sleep = 1; tx_idle = 0; step(3);
        chk("R4", "tx busy", pm_state, 0);
        tx_idle = 1; rx_idle = 0; step(3);
        chk("R4", "rx busy", pm_state, 0);
        rx_idle = 1; irq_pending = 1; step(3);
        chk("R4", "irq pending", pm_state, 0);
        irq_pending = 0; bus_access = 1; step(1);
        chk("R4", "wake event", pm_state, 0);
        bus_access = 0; sw_sleep = 0;

        // R5: autosleep in the awake state is ignored
        autosleep = 1; step(4);
        chk("R5", "awake autosleep", pm_state, 0);
        chk("R5", "pump kept", pump_en, 1);
        autosleep = 0;

        // R3: hardware request enters light sleep
        hw_sleep = 1; step(1);
        chk("R3", "hw entry", pm_state, 1);
        hw_sleep = 0; step(2);
        // R5: autosleep deepens
        autosleep = 1; step(1);
        chk("R5", "deepen", pm_state, 2);
        chk("R2", "pump off", pump_en, 0);
        autosleep = 0; step(2);
        // R6/R8: line activity wakes from deep sleep, ready held
        rx_activity = 1; step(1);
        rx_activity = 0;
        chk("R6", "deep wake", pm_state, 0);
        chk("R7", "flag set", wake_irq, 1);
        chk("R8", "not ready", ready, 0);
        // R4: wake flag and unsettled pump block re-entry
        sw_sleep = 1; step(4 * WT - 8);
        chk("R8", "still settling", ready, 0);
        chk("R4", "blocked", pm_state, 0);
        step(16);
        chk("R8", "settled", ready, 1);
        chk("R4", "flag blocks", pm_state, 0);
        // R7: status read clears, then software entry proceeds
        isr_read = 1; step(1);
        isr_read = 0;
        chk("R7", "cleared", wake_irq, 0);
        step(1);
        chk("R3", "sw entry", pm_state, 1);
        sw_sleep = 0; step(2);
        // R6/R8/R7: bus access wakes from light sleep; set beats clear
        bus_access = 1; isr_read = 1; step(1);
        bus_access = 0; isr_read = 0;
        chk("R6", "light wake", pm_state, 0);
        chk("R8", "ready now", ready, 1);
        chk("R7", "set wins", wake_irq, 1);
        isr_read = 1; step(1); isr_read = 0;
        // R6: wake beats autosleep in light sleep
        hw_sleep = 1; step(1); hw_sleep = 0;
        chk("R3", "re-entry", pm_state, 1);
        autosleep = 1; rx_activity = 1; step(1);
        autosleep = 0; rx_activity = 0;
        chk("R6", "wake priority", pm_state, 0);
        step(3);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule